// File: doc/BRIEF.md
# Systolic Negacyclic Polynomial Multiplier

This block multiplies two polynomials of length n whose coefficients lie in [0, M) for a prime M. The product is reduced in the ring where x^n equals -1, so it also has n coefficients. The work is spread over a row of n cells. Each cell owns one output coefficient and has its own multiply-accumulate unit followed by a modulo-M reduction. The whole product is therefore ready in about n cycles instead of n squared.

The operand B is presented as one wide word and captured by a start pulse. The operand A then enters through a narrow port, one coefficient per cycle, lowest degree first. Each cell adds the product of the incoming A coefficient and the B value it currently holds. After that, every held B value moves up one cell. The value that leaves the top cell comes back into cell 0 negated. This folds terms whose degree reaches n back onto the low coefficients with a sign change. When the last coefficient of A has been used, a done pulse marks the result as valid. The result is read in parallel and is held until the next accepted start.

Top module: `negacyclic_mul`

## Requirements
- R1: While reset is held, and directly after it, busy and done are 0 and every result coefficient reads 0.
- R2: A start sampled while busy is 0 captures b_in, clears all accumulators and raises busy at that edge. Coefficient j of B sits at bits [j*W +: W] of b_in, with W = ceil(log2 M).
- R3: done rises exactly n clock edges after the edge that accepted start. In that same cycle busy falls. done stays high for exactly one cycle.
- R4: When done is high, coefficient j of c_out, at bits [j*W +: W], equals the sum over i+k=j of a_i*b_k minus the sum over i+k=j+n of a_i*b_k, taken modulo M and lying in [0, M).
- R5: A product a_i*b_k with i+k >= n is subtracted from coefficient i+k-n, not added. For example, A = x^(n-1) times B = x gives coefficient 0 equal to M-1 and all others 0.
- R6: A start sampled while busy is 1 is ignored. It does not restart the run, does not move the done pulse, and does not replace the captured B, even if b_in changes with it.
- R7: a_in is taken only in busy cycles. Coefficient a_k is used in the k-th cycle after the accepting edge. The value on a_in in the start cycle has no effect.
- R8: After done, c_out holds its value while no new start is accepted, whatever a_in does.
- R9: A start asserted in the cycle where done is high is accepted. The next product is computed from cleared accumulators.
- R10: Inputs whose coefficients all equal M-1 give the exactly reduced product, with no overflow inside a cell.
- R11: The same behaviour holds for other parameter choices, for example n = 8 with M = 7681.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a multiplication when idle |
| b_in | input | N*W | All coefficients of B, coefficient j at [j*W +: W] |
| a_in | input | W | Current coefficient of A during busy cycles |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse, result valid |
| c_out | output | N*W | Product coefficients, coefficient j at [j*W +: W] |

## Verification
Two things can land in the same cycle: the done pulse of one product and the start of the next. The bench reads the finished result in the done cycle and raises start in that same cycle with a new B. It then checks three things: busy comes back at the next edge, done does not repeat, and the second result matches a fresh reference rather than a sum with the first one. A start raised in the middle of a busy run, with a different b_in, is the other collision. It is judged by an unchanged done time and an unchanged product.

// File: rtl/negacyclic_mul.sv
module negacyclic_mul #(
  parameter int N = 256,
  parameter int M = 12289,
  localparam int W = $clog2(M)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N*W-1:0] b_in,
  input  logic [W-1:0] a_in,
  output logic         busy,
  output logic         done,
  output logic [N*W-1:0] c_out
);
  localparam int CW = $clog2(N + 1);
  localparam int PW = 2 * W + 1;

  logic [CW-1:0] cnt;
  logic [W-1:0]  rot [N];
  logic [W-1:0]  acc [N];
  logic          load, step;

  assign load = start && !busy;
  assign step = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (step) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(N - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_cell
    logic [W-1:0]  feed;
    logic [PW-1:0] sum;
    logic [W-1:0]  nxt;

    if (j == 0) begin : g_wrap
      assign feed = (rot[N-1] == '0) ? '0 : W'(M - int'(rot[N-1]));
    end else begin : g_pass
      assign feed = rot[j-1];
    end

    assign sum = PW'((2*W)'(a_in) * (2*W)'(rot[j])) + PW'(acc[j]);
    assign nxt = W'(sum % PW'(M));
    assign c_out[j*W +: W] = acc[j];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rot[j] <= '0;
        acc[j] <= '0;
      end else if (load) begin
        rot[j] <= b_in[j*W +: W];
        acc[j] <= '0;
      end else if (step) begin
        rot[j] <= feed;
        acc[j] <= nxt;
      end
    end
  end
endmodule

// File: rtl/negacyclic_mul_chk.sv
module negacyclic_mul_chk #(
  parameter int N = 256,
  parameter int M = 12289,
  localparam int W = $clog2(M),
  localparam int CW = $clog2(N + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [CW-1:0]  cnt,
  input logic [N*W-1:0] c_out
);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R6
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> (cnt == $past(cnt) + 1'b1));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(c_out));

  for (genvar j = 0; j < N; j++) begin : g_rng
    // R4
    coef_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(c_out[j*W +: W]) < M));
  end
endmodule

bind negacyclic_mul negacyclic_mul_chk #(.N(N), .M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .cnt(cnt), .c_out(c_out)
);

// File: tb/negacyclic_mul_test.sv
module negacyclic_mul_test;
  localparam int N = 256, M = 12289, W = $clog2(M);
  localparam int N2 = 8, M2 = 7681, W2 = $clog2(M2);
  // pattern code, seed: 0 random, 1 all M-1, 2 zero A, 3 impulse, 4 B all ones
  localparam int VEC [5][2] = '{'{0, 11}, '{1, 0}, '{3, 0}, '{0, 977}, '{4, 5}};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, busy, done;
  logic [N*W-1:0] b_in, c_out;
  logic [W-1:0]   a_in;
  logic start2, busy2, done2;
  logic [N2*W2-1:0] b2, c2;
  logic [W2-1:0]    a2;

  negacyclic_mul #(.N(N), .M(M)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .b_in(b_in), .a_in(a_in),
    .busy(busy), .done(done), .c_out(c_out));

  negacyclic_mul #(.N(N2), .M(M2)) uut2 (
    .clk(clk), .rst_n(rst_n), .start(start2), .b_in(b2), .a_in(a2),
    .busy(busy2), .done(done2), .c_out(c2));

  int ga [N];
  int gb [N];
  int gc [N];
  int unsigned lcg;
  int checks = 0, fails = 0;

  function automatic int rnd(int m);
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return int'((lcg >> 16) % m);
  endfunction

  function automatic void fill(int pat, int seed, int n, int m);
    lcg = seed;
    for (int i = 0; i < N; i++) begin ga[i] = 0; gb[i] = 0; end
    for (int i = 0; i < n; i++) begin
      case (pat)
        0: begin ga[i] = rnd(m); gb[i] = rnd(m); end
        1: begin ga[i] = m - 1; gb[i] = m - 1; end
        2: begin ga[i] = 0; gb[i] = rnd(m); end
        4: begin ga[i] = rnd(m); gb[i] = 1; end
        default: ;
      endcase
    end
    if (pat == 3) begin ga[n-1] = 1; gb[1] = 1; end
  endfunction

  function automatic void negref(int n, int m);
    for (int i = 0; i < N; i++) gc[i] = 0;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < n; k++) begin
        int p = int'((longint'(ga[i]) * gb[k]) % m);
        if (i + k < n) gc[i+k] = (gc[i+k] + p) % m;
        else gc[i+k-n] = (gc[i+k-n] + m - p) % m;
      end
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_big(string req);
    int bad = -1;
    for (int j = N - 1; j >= 0; j--)
      if (int'(c_out[j*W +: W]) != gc[j]) bad = j;
    if (bad < 0) chk(1'b1, req, "product", 0, 0);
    else chk(1'b0, req, $sformatf("coef %0d", bad), c_out[bad*W +: W], gc[bad]);
  endtask

  task automatic start_run();
    for (int j = 0; j < N; j++) b_in[j*W +: W] = W'(gb[j]);
    a_in = W'(M - 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R2", "busy after start", {busy, done}, 2);
  endtask

  task automatic stream_finish(bit poke);
    int early = 0;
    for (int k = 0; k < N; k++) begin
      a_in = W'(ga[k]);
      if (poke && k == N / 2) begin start = 1'b1; b_in = '0; end
      @(negedge clk);
      start = 1'b0;
      if (k < N - 1 && (done || !busy)) early++;
    end
    chk(early == 0, "R3", "done early or busy dropped", early, 0);
    chk(done && !busy, "R3", "done at n edges", {busy, done}, 1);
  endtask

  task automatic small_run(int pat, int seed);
    int bad = -1;
    fill(pat, seed, N2, M2);
    negref(N2, M2);
    @(negedge clk);
    for (int j = 0; j < N2; j++) b2[j*W2 +: W2] = W2'(gb[j]);
    start2 = 1'b1;
    @(negedge clk);
    start2 = 1'b0;
    for (int k = 0; k < N2; k++) begin a2 = W2'(ga[k]); @(negedge clk); end
    for (int j = N2 - 1; j >= 0; j--) if (int'(c2[j*W2 +: W2]) != gc[j]) bad = j;
    chk(done2, "R11", "small done", done2, 1);
    if (bad < 0) chk(1'b1, "R11", "small product", 0, 0);
    else chk(1'b0, "R11", $sformatf("small coef %0d", bad), c2[bad*W2 +: W2], gc[bad]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; b_in = '0; a_in = '0;
    start2 = 1'b0; b2 = '0; a2 = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && c_out == '0, "R1", "reset state", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && c_out == '0, "R1", "after reset", {busy, done}, 0);

    for (int v = 0; v < 5; v++) begin
      fill(VEC[v][0], VEC[v][1], N, M);
      negref(N, M);
      start_run();
      stream_finish(1'b0);
      cmp_big(VEC[v][0] == 1 ? "R10" : "R4 R7");
      if (VEC[v][0] == 3)
        chk(int'(c_out[W-1:0]) == M - 1, "R5", "wrap negation", c_out[W-1:0], M - 1);
      @(negedge clk);
      chk(!done, "R3", "done single cycle", done, 0);
    end

    // R6: start with different b_in in mid-run
    fill(0, 31, N, M);
    negref(N, M);
    @(negedge clk);
    start_run();
    stream_finish(1'b1);
    cmp_big("R6");

    // R8: hold while a_in wanders
    for (int t = 0; t < 5; t++) begin a_in = W'(rnd(M)); @(negedge clk); end
    cmp_big("R8");

    // R9: start in the done cycle
    fill(0, 404, N, M);
    negref(N, M);
    start_run();
    stream_finish(1'b0);
    cmp_big("R9");
    fill(0, 77, N, M);
    negref(N, M);
    start_run();
    chk(!done, "R9", "no repeat done", done, 0);
    stream_finish(1'b0);
    cmp_big("R9");

    small_run(0, 5);
    small_run(1, 0);
    small_run(3, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule